// File: doc/BRIEF.md
# Segmented Burst Store-and-Forward Buffer

This buffer sits between the producer and consumer halves of a DMA data path and stores whole bursts before forwarding them. Its RAM is split into `NUM_SEG` equal segments, each one maximum-length burst (`MAX_BEATS` beats) deep. Every burst is given a segment of its own, whatever its length, so placement is always segment-aligned and the next burst always starts at the following segment.

The producer first reserves room by requesting a burst; requests are granted only while a segment is free for them, so the producer never gets ahead of the storage and beats need no ready signal. Beats then arrive with a last flag. On the consumer side the buffer drives a valid/ready stream with a last flag it generates itself from the stored burst length, plus an ID that counts the bursts that have become readable. An occupancy output gives the number of stored bursts not yet drained.

Top module: `burst_seg_buffer`

## Requirements
- R1: After reset `dst_valid` is 0, `occupancy` is 0, `dst_id` is 0 and `src_req_ready` is 1.
- R2: `src_req_ready` is 0 exactly when `NUM_SEG` bursts have been granted and not yet fully read; a request made while it is 0 is not granted and reserves nothing.
- R3: Each burst occupies its own segment, so bursts of any length from 1 to `MAX_BEATS` are read back in write order with every beat intact.
- R4: A burst closes on a beat with `src_beat_last` = 1, or on its `MAX_BEATS`-th beat even if that flag is 0; the next beat then starts a new burst.
- R5: `dst_last` is 1 on the final stored beat of each burst and 0 on every other beat.
- R6: `dst_id` advances by one (modulo 2·`NUM_SEG`) on the clock edge that captures a burst's closing beat, the same edge on which that burst becomes readable (`dst_valid` = 1, `occupancy` up by one).
- R7: While `dst_valid` is 1 and `dst_ready` is 0, `dst_valid`, `dst_data` and `dst_last` hold their values.
- R8: `occupancy` equals closed bursts minus bursts whose last beat has been read, in the range 0 to `NUM_SEG`, and `dst_valid` is 1 exactly when it is nonzero.
- R9: Reading the last beat of a burst frees its segment, so `src_req_ready` returns to 1 on the next cycle after a full buffer is partly drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req_valid | input | 1 | Producer asks to reserve one burst |
| src_req_ready | output | 1 | Reservation granted when high with `src_req_valid` |
| src_beat_valid | input | 1 | Producer beat present |
| src_beat_data | input | DATA_W | Producer beat data |
| src_beat_last | input | 1 | Marks the closing beat of a burst |
| dst_valid | output | 1 | Consumer beat available |
| dst_ready | input | 1 | Consumer accepts the beat |
| dst_data | output | DATA_W | Consumer beat data |
| dst_last | output | 1 | Final beat of the current burst |
| dst_id | output | log2(NUM_SEG)+1 | Count of bursts made readable, modulo 2·NUM_SEG |
| occupancy | output | log2(NUM_SEG)+1 | Stored bursts not yet drained |

## Verification
The checks assume the producer only sends beats for bursts it has already been granted and never sends more than `MAX_BEATS` beats per burst without closing it. The stimulus always reserves a burst before writing its beats, and the fill sequence reserves four bursts before writing all four, one of them closed only by the beat limit. Grants and drains are tallied independently of the design, so the outstanding-burst bound is checked against port activity alone.

// File: rtl/burst_seg_buffer.sv
module burst_seg_buffer #(
  parameter int DATA_W    = 8,
  parameter int NUM_SEG   = 4,
  parameter int MAX_BEATS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        src_req_valid,
  output logic                        src_req_ready,
  input  logic                        src_beat_valid,
  input  logic [DATA_W-1:0]           src_beat_data,
  input  logic                        src_beat_last,
  output logic                        dst_valid,
  input  logic                        dst_ready,
  output logic [DATA_W-1:0]           dst_data,
  output logic                        dst_last,
  output logic [$clog2(NUM_SEG):0]    dst_id,
  output logic [$clog2(NUM_SEG):0]    occupancy
);
  localparam int SEG_AW = $clog2(NUM_SEG);
  localparam int BEAT_AW = $clog2(MAX_BEATS);
  localparam int PTR_W = SEG_AW + 1;
  localparam int DEPTH = NUM_SEG * MAX_BEATS;

  logic [DATA_W-1:0]  mem     [DEPTH];
  logic [BEAT_AW-1:0] len_mem [NUM_SEG];

  logic [PTR_W-1:0]   req_ptr, wr_seg, rd_seg;
  logic [BEAT_AW-1:0] wr_beat, rd_beat;

  wire [PTR_W-1:0] reserved = req_ptr - rd_seg;
  wire req_fire = src_req_valid && src_req_ready;
  wire wr_close = src_beat_valid && (src_beat_last || wr_beat == BEAT_AW'(MAX_BEATS - 1));
  wire rd_fire  = dst_valid && dst_ready;

  assign src_req_ready = reserved != PTR_W'(NUM_SEG);
  assign occupancy     = wr_seg - rd_seg;
  assign dst_valid     = occupancy != '0;
  assign dst_id        = wr_seg;
  assign dst_data      = mem[{rd_seg[SEG_AW-1:0], rd_beat}];
  assign dst_last      = rd_beat == len_mem[rd_seg[SEG_AW-1:0]];

  always_ff @(posedge clk) begin
    if (src_beat_valid) begin
      mem[{wr_seg[SEG_AW-1:0], wr_beat}] <= src_beat_data;
      if (wr_close) len_mem[wr_seg[SEG_AW-1:0]] <= wr_beat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ptr <= '0;
      wr_seg  <= '0;
      wr_beat <= '0;
      rd_seg  <= '0;
      rd_beat <= '0;
    end else begin
      if (req_fire) req_ptr <= req_ptr + 1'b1;
      if (src_beat_valid) begin
        if (wr_close) begin
          wr_seg  <= wr_seg + 1'b1;
          wr_beat <= '0;
        end else begin
          wr_beat <= wr_beat + 1'b1;
        end
      end
      if (rd_fire) begin
        if (dst_last) begin
          rd_seg  <= rd_seg + 1'b1;
          rd_beat <= '0;
        end else begin
          rd_beat <= rd_beat + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/burst_seg_buffer_chk.sv
module burst_seg_buffer_chk #(
  parameter int DATA_W  = 8,
  parameter int NUM_SEG = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     src_req_valid,
  input logic                     src_req_ready,
  input logic                     dst_valid,
  input logic                     dst_ready,
  input logic [DATA_W-1:0]        dst_data,
  input logic                     dst_last,
  input logic [$clog2(NUM_SEG):0] dst_id,
  input logic [$clog2(NUM_SEG):0] occupancy
);
  int outstanding;
  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 0;
    else outstanding <= outstanding + int'(src_req_valid && src_req_ready)
                        - int'(dst_valid && dst_ready && dst_last);
  end

  // R2
  grant_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= NUM_SEG);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !dst_ready |=> dst_valid && $stable(dst_data) && $stable(dst_last));

  // R8
  occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= ($clog2(NUM_SEG)+1)'(NUM_SEG) && (dst_valid == (occupancy != '0)));

  // R6
  id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_id != $past(dst_id) |-> dst_id == $past(dst_id) + 1'b1 && occupancy != '0);

  // R2
  req_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy == ($clog2(NUM_SEG)+1)'(NUM_SEG) |-> !src_req_ready);
endmodule

bind burst_seg_buffer burst_seg_buffer_chk #(.DATA_W(DATA_W), .NUM_SEG(NUM_SEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req_valid(src_req_valid), .src_req_ready(src_req_ready),
  .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data), .dst_last(dst_last),
  .dst_id(dst_id), .occupancy(occupancy)
);

// File: tb/burst_seg_buffer_bench.sv
module burst_seg_buffer_bench;
  localparam int DATA_W = 8, NUM_SEG = 4, MAX_BEATS = 8, PW = 3;

  logic clk = 0, rst_n = 0;
  logic src_req_valid = 0, src_beat_valid = 0, src_beat_last = 0, dst_ready = 0;
  logic [DATA_W-1:0] src_beat_data = '0;
  logic src_req_ready, dst_valid, dst_last;
  logic [DATA_W-1:0] dst_data;
  logic [PW-1:0] dst_id, occupancy;

  int total = 0, bad = 0, committed = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  burst_seg_buffer #(.DATA_W(DATA_W), .NUM_SEG(NUM_SEG), .MAX_BEATS(MAX_BEATS)) u_burst_seg_buffer (
    .clk(clk), .rst_n(rst_n), .src_req_valid(src_req_valid), .src_req_ready(src_req_ready),
    .src_beat_valid(src_beat_valid), .src_beat_data(src_beat_data), .src_beat_last(src_beat_last),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data), .dst_last(dst_last),
    .dst_id(dst_id), .occupancy(occupancy));

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_req(output bit acc);
    src_req_valid = 1;
    #1 acc = src_req_ready;
    @(negedge clk);
    src_req_valid = 0;
  endtask

  task automatic write_beats(int n, int base, bit mark_last);
    for (int i = 0; i < n; i++) begin
      src_beat_valid = 1;
      src_beat_data  = DATA_W'(base + i);
      src_beat_last  = mark_last && (i == n - 1);
      @(negedge clk);
    end
    src_beat_valid = 0;
    src_beat_last  = 0;
  endtask

  task automatic read_burst(int n, int base);
    for (int i = 0; i < n; i++) begin
      #1;
      chk(dst_valid == 1, "R8 valid", int'(dst_valid), 1);
      chk(dst_data == DATA_W'(base + i), "R3 data", int'(dst_data), base + i);
      chk(dst_last == (i == n - 1), "R5 last", int'(dst_last), int'(i == n - 1));
      dst_ready = 1;
      @(negedge clk);
      dst_ready = 0;
    end
  endtask

  initial begin
    bit acc;
    logic [DATA_W-1:0] held;
    repeat (3) @(negedge clk);
    #1;
    chk(dst_valid == 0, "R1 valid", int'(dst_valid), 0);
    chk(occupancy == 0, "R1 occupancy", int'(occupancy), 0);
    chk(dst_id == 0, "R1 id", int'(dst_id), 0);
    chk(src_req_ready == 1, "R1 req_ready", int'(src_req_ready), 1);
    rst_n = 1;
    @(negedge clk);

    for (int len = 1; len <= MAX_BEATS; len++) begin
      do_req(acc);
      chk(acc == 1, "R2 grant", int'(acc), 1);
      write_beats(len, len * 16, 1);
      committed++;
      #1;
      chk(dst_id == PW'(committed), "R6 id", int'(dst_id), committed % 8);
      chk(occupancy == 1, "R8 occupancy", int'(occupancy), 1);
      @(negedge clk);
      read_burst(len, len * 16);
      #1 chk(occupancy == 0, "R8 drained", int'(occupancy), 0);
      @(negedge clk);
    end

    for (int k = 0; k < NUM_SEG; k++) begin
      do_req(acc);
      chk(acc == 1, "R2 fill grant", int'(acc), 1);
    end
    do_req(acc);
    chk(acc == 0, "R2 refused", int'(acc), 0);
    write_beats(3, 8'h40, 1);
    write_beats(1, 8'h50, 1);
    write_beats(8, 8'h60, 0);
    write_beats(2, 8'h70, 1);
    committed += 4;
    #1;
    chk(occupancy == 4, "R4 occupancy", int'(occupancy), 4);
    chk(dst_id == PW'(committed), "R6 id fill", int'(dst_id), committed % 8);
    chk(src_req_ready == 0, "R2 full", int'(src_req_ready), 0);
    held = dst_data;
    repeat (3) @(negedge clk);
    #1;
    chk(dst_valid == 1, "R7 valid held", int'(dst_valid), 1);
    chk(dst_data == held, "R7 data held", int'(dst_data), int'(held));
    @(negedge clk);
    read_burst(3, 8'h40);
    #1 chk(src_req_ready == 1, "R9 freed", int'(src_req_ready), 1);
    chk(occupancy == 3, "R9 occupancy", int'(occupancy), 3);
    @(negedge clk);
    read_burst(1, 8'h50);
    read_burst(8, 8'h60);
    read_burst(2, 8'h70);
    #1 chk(occupancy == 0, "R8 empty", int'(occupancy), 0);
    chk(dst_valid == 0, "R8 no valid", int'(dst_valid), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule